// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received frame, whether its 48-bit destination address is wanted. It combines two tables. The first is a small array of exact-match entries, each with its own valid flag. Entry 0 is meant for the station's own unicast address, and the others are free for multicast groups. The second is a 4096-bit multicast hash table. Its 12-bit index is cut from one of four selectable windows of upper address bits.

Software reaches both tables through a simple register-style port with a write strobe, a read strobe, a 9-bit word address and 32-bit data. Read data returns one clock after the read strobe. The port can overwrite whole hash words, and it can also set a single hash bit. A small sequencer carries out the single-bit set with three states: `HS_IDLE`, `HS_LOAD` and `HS_STORE`. A set command accepted in `HS_IDLE` moves it to `HS_LOAD`. There the addressed word is fetched and the new bit is ORed in. `HS_LOAD` always moves to `HS_STORE`, which writes the merged word back, and `HS_STORE` always returns to `HS_IDLE`. Set commands that arrive while the sequencer is busy are dropped, so software spaces them at least three cycles apart.

On the frame side, a destination address arrives with a strobe. Exactly one clock later the block returns a verdict: accept or reject, a reason code, and the index of the exact entry that hit.

Word map of the register port:
- Words 0 to 31 hold the exact entries. Entry e uses word 2e for its low half and word 2e+1 for its high half.
- Words 128 to 255 are the hash words.
- Word 256 holds the window select.
- A write to word 257 requests a single-bit set.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset every valid flag, every hash bit and the window select are zero. No address is accepted, and every table word reads back as zero.
- R2: An address is accepted with reason EXACT (code 1) when a valid entry equals all 48 of its bits. `hit_entry` gives the lowest-numbered matching entry. An address that differs in any bit from every valid entry gets no exact hit.
- R3: Layout of an exact entry:
  - The address is carried on `da` with byte 0 in bits [7:0], so `da[31:0]` holds bytes 0 to 3 little-endian and `da[47:32]` holds bytes 4 and 5.
  - The low word (address 2e) holds `da[31:0]`.
  - The high word (address 2e+1) holds `da[47:32]` in bits [15:0] and the valid flag in bit 31.
  - Bits [30:16] of the high word read back as zero.
- R4: Writing a high word with bit 31 clear removes the entry from matching at once, even though its low word still holds the address.
- R5: The window select (word 256, bits [1:0]) picks the hash index:
  - 0 takes address bits [47:36].
  - 1 takes [46:35].
  - 2 takes [45:34].
  - 3 takes [43:32].
- R6: Hash index bits [11:5] choose the hash word (address 128 + word), and bits [4:0] choose the bit inside that word. Hash words can be written and read directly.
- R7: A write to word 257 sets hash bit `wdata[11:0]` and leaves every other bit of that word unchanged. The new bit affects lookups strobed three or more edges after the command edge.
- R8: Only an address with its group bit set (`da[0]` = 1) can be accepted through the hash table. The reason code for a hash accept is HASH (code 2).
- R9: Timing and priority of the verdict:
  - `hit_valid` rises exactly one clock after `da_valid`.
  - Reason NONE (code 0) comes with accept low and `hit_entry` 0.
  - An exact hit takes priority over a hash hit.
- R10: A lookup strobed in the same cycle as a table write sees the table contents from before that write.
- R11: The window select reads back from word 256 in bits [1:0]. Reads of unmapped words return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 9 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data, one clock after `cfg_rd` |
| cfg_rvalid | output | 1 | Read data valid |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits [7:0] |
| hit_valid | output | 1 | Verdict valid, one clock after `da_valid` |
| hit_accept | output | 1 | Frame accepted |
| hit_reason | output | 2 | 0 none, 1 exact, 2 hash |
| hit_entry | output | 4 | Matching exact entry index |

## Verification
The bench builds the block with its default parameters: 16 exact entries and a 4096-bit hash table held as 128 words. With these values every entry can be reached, including the priority between duplicate entries. All four index windows can be exercised against the full hash array, and any hash word can be read back after single-bit sets. A behavioural model holds the tables as plain bit arrays and keeps pending bit-sets in a queue. Every clock it is compared with the verdict and read-back ports. This covers same-cycle write and lookup collisions and the three-edge latency of the bit-set sequencer.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    localparam int MAC_W       = 48;
    localparam int WORD_W      = 32;
    localparam int HASH_IDX_W  = 12;
    localparam int HASH_BIT_W  = 5;
    localparam int HASH_WA_W   = HASH_IDX_W - HASH_BIT_W;
    localparam int HASH_WORDS  = 1 << HASH_WA_W;
    localparam int HI_ADDR_W   = MAC_W - WORD_W;
    localparam int VALID_BIT   = 31;
    localparam int CFG_AW      = 9;

    localparam logic [CFG_AW-1:0] HASH_BASE   = 9'd128;
    localparam logic [CFG_AW-1:0] TYPE_ADDR   = 9'd256;
    localparam logic [CFG_AW-1:0] SETBIT_ADDR = 9'd257;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'd0,
        RSN_EXACT = 2'd1,
        RSN_HASH  = 2'd2
    } reason_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_LOAD  = 2'd1,
        HS_STORE = 2'd2
    } hset_e;

    function automatic logic [HASH_IDX_W-1:0] hash_pick(
        input logic [MAC_W-1:0] addr,
        input logic [1:0]       sel
    );
        logic [HASH_IDX_W-1:0] r;
        unique case (sel)
            2'd0:    r = addr[47:36];
            2'd1:    r = addr[46:35];
            2'd2:    r = addr[45:34];
            default: r = addr[43:32];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rdf_exact_table.sv
module rdf_exact_table
    import rdf_pkg::*;
#(
    parameter  int N_ENTRY = 16,
    localparam int IDX_W   = $clog2(N_ENTRY),
    localparam int WA_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WA_W-1:0]   rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic [MAC_W-1:0]  da,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [WORD_W-1:0]    lo_q [N_ENTRY];
    logic [HI_ADDR_W-1:0] hi_q [N_ENTRY];
    logic [N_ENTRY-1:0]   vld_q;
    logic [N_ENTRY-1:0]   match_vec;
    logic [IDX_W-1:0]     wr_ent;
    logic [IDX_W-1:0]     rd_ent;

    assign wr_ent = wr_word[WA_W-1:1];
    assign rd_ent = rd_word[WA_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
            vld_q <= '0;
        end else if (wr_en) begin
            if (!wr_word[0]) begin
                lo_q[wr_ent] <= wr_data;
            end else begin
                hi_q[wr_ent]  <= wr_data[HI_ADDR_W-1:0];
                vld_q[wr_ent] <= wr_data[VALID_BIT];
            end
        end
    end

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign match_vec[g] = vld_q[g] && ({hi_q[g], lo_q[g]} == da);
    end

    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_word[0]) begin
            rd_data[HI_ADDR_W-1:0] = hi_q[rd_ent];
            rd_data[VALID_BIT]     = vld_q[rd_ent];
        end else begin
            rd_data = lo_q[rd_ent];
        end
    end

    // R4: clearing the valid bit stops that entry matching on the next cycle
    p_hi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[0] && !wr_data[VALID_BIT])
            |=> !match_vec[$past(wr_ent)]);

    // R2: reported index always names a matching entry
    p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);

endmodule

// File: rtl/rdf_hash_table.sv
module rdf_hash_table
    import rdf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [HASH_WA_W-1:0]  wr_word,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  set_req,
    input  logic [HASH_IDX_W-1:0] set_idx,
    input  logic [HASH_WA_W-1:0]  rd_word,
    output logic [WORD_W-1:0]     rd_data,
    input  logic [HASH_IDX_W-1:0] lk_idx,
    output logic                  lk_bit
);

    logic [WORD_W-1:0]     mem_q [HASH_WORDS];
    hset_e                 st_q, st_d;
    logic [HASH_IDX_W-1:0] idx_q;
    logic [WORD_W-1:0]     hold_q;
    logic [HASH_WA_W-1:0]  tgt_word;
    logic [HASH_BIT_W-1:0] tgt_bit;

    assign tgt_word = idx_q[HASH_IDX_W-1:HASH_BIT_W];
    assign tgt_bit  = idx_q[HASH_BIT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE:  if (set_req) st_d = HS_LOAD;
            HS_LOAD:  st_d = HS_STORE;
            HS_STORE: st_d = HS_IDLE;
            default:  st_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            hold_q <= '0;
        end else begin
            if (st_q == HS_IDLE && set_req) idx_q <= set_idx;
            if (st_q == HS_LOAD) hold_q <= mem_q[tgt_word] | (WORD_W'(1) << tgt_bit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HASH_WORDS; i++) mem_q[i] <= '0;
        end else begin
            if (wr_en) mem_q[wr_word] <= wr_data;
            if (st_q == HS_STORE) mem_q[tgt_word] <= hold_q;
        end
    end

    assign rd_data = mem_q[rd_word];
    assign lk_bit  = mem_q[lk_idx[HASH_IDX_W-1:HASH_BIT_W]][lk_idx[HASH_BIT_W-1:0]];

    // R7: fetch is always followed by write-back
    p_load_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_LOAD) |=> (st_q == HS_STORE));

    // R7: after write-back the requested bit is set
    p_bit_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_STORE) |=> mem_q[$past(tgt_word)][$past(tgt_bit)]);

endmodule

// File: rtl/rdf_decide.sv
module rdf_decide
    import rdf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             da_valid,
    input  logic             group_bit,
    input  logic             exact_hit,
    input  logic [IDX_W-1:0] exact_idx,
    input  logic             hash_bit,
    output logic             out_valid,
    output logic             out_accept,
    output reason_e          out_reason,
    output logic [IDX_W-1:0] out_idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
            out_reason <= RSN_NONE;
            out_idx    <= '0;
        end else begin
            out_valid  <= da_valid;
            out_accept <= 1'b0;
            out_reason <= RSN_NONE;
            out_idx    <= '0;
            if (da_valid) begin
                if (exact_hit) begin
                    out_accept <= 1'b1;
                    out_reason <= RSN_EXACT;
                    out_idx    <= exact_idx;
                end else if (group_bit && hash_bit) begin
                    out_accept <= 1'b1;
                    out_reason <= RSN_HASH;
                end
            end
        end
    end

    // R9: a verdict only follows a strobe
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(da_valid));

    // R8: hash accept needs the group bit
    p_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_reason == RSN_HASH) |-> $past(group_bit));

    // R9: exact match wins over hash
    p_exact_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(exact_hit)) |-> (out_reason == RSN_EXACT));

    // R9: accept agrees with reason
    p_accept_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> (out_reason != RSN_NONE));

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rdf_pkg::*;
#(
    parameter  int N_ENTRY = 16,
    localparam int IDX_W   = $clog2(N_ENTRY),
    localparam int EX_AW   = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic [WORD_W-1:0]   cfg_rdata,
    output logic                cfg_rvalid,
    input  logic                da_valid,
    input  logic [MAC_W-1:0]    da,
    output logic                hit_valid,
    output logic                hit_accept,
    output logic [1:0]          hit_reason,
    output logic [IDX_W-1:0]    hit_entry
);

    localparam logic [CFG_AW-1:0] EX_LIMIT  = CFG_AW'(2 * N_ENTRY);
    localparam logic [CFG_AW-1:0] HASH_LAST = HASH_BASE + CFG_AW'(HASH_WORDS - 1);

    logic                  in_exact, in_hash;
    logic [1:0]            type_q;
    logic [WORD_W-1:0]     ex_rd, hs_rd;
    logic                  ex_hit, hs_bit;
    logic [IDX_W-1:0]      ex_idx;
    logic [HASH_IDX_W-1:0] lk_idx;
    reason_e               rsn;

    assign in_exact = cfg_addr < EX_LIMIT;
    assign in_hash  = (cfg_addr >= HASH_BASE) && (cfg_addr <= HASH_LAST);
    assign lk_idx   = hash_pick(da, type_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              type_q <= 2'd0;
        else if (cfg_wr && cfg_addr == TYPE_ADDR) type_q <= cfg_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (cfg_rd) begin
                if (in_exact)                    cfg_rdata <= ex_rd;
                else if (in_hash)                cfg_rdata <= hs_rd;
                else if (cfg_addr == TYPE_ADDR)  cfg_rdata <= {30'd0, type_q};
                else                             cfg_rdata <= '0;
            end
        end
    end

    rdf_exact_table #(.N_ENTRY(N_ENTRY)) u_exact (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr && in_exact),
        .wr_word (cfg_addr[EX_AW-1:0]),
        .wr_data (cfg_wdata),
        .rd_word (cfg_addr[EX_AW-1:0]),
        .rd_data (ex_rd),
        .da      (da),
        .hit     (ex_hit),
        .hit_idx (ex_idx)
    );

    rdf_hash_table u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr && in_hash),
        .wr_word (cfg_addr[HASH_WA_W-1:0]),
        .wr_data (cfg_wdata),
        .set_req (cfg_wr && cfg_addr == SETBIT_ADDR),
        .set_idx (cfg_wdata[HASH_IDX_W-1:0]),
        .rd_word (cfg_addr[HASH_WA_W-1:0]),
        .rd_data (hs_rd),
        .lk_idx  (lk_idx),
        .lk_bit  (hs_bit)
    );

    rdf_decide #(.IDX_W(IDX_W)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .da_valid   (da_valid),
        .group_bit  (da[0]),
        .exact_hit  (ex_hit),
        .exact_idx  (ex_idx),
        .hash_bit   (hs_bit),
        .out_valid  (hit_valid),
        .out_accept (hit_accept),
        .out_reason (rsn),
        .out_idx    (hit_entry)
    );

    assign hit_reason = rsn;

    // R11: read data only appears after a read strobe
    p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd));

endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        hit_valid, hit_accept;
    logic [1:0]  hit_reason;
    logic [3:0]  hit_entry;

    always #2.5 clk = ~clk;

    rx_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .da_valid(da_valid), .da(da),
        .hit_valid(hit_valid), .hit_accept(hit_accept),
        .hit_reason(hit_reason), .hit_entry(hit_entry)
    );

    int    n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_tag = "R1";

    // behavioural model state
    logic [47:0] m_addr [16];
    bit          m_vld  [16];
    bit          m_hash [4096];
    int          m_type;
    int          pend_idx[$];
    int          pend_cnt[$];

    logic        e_valid = 0, e_acc = 0, e_rvalid = 0;
    logic [1:0]  e_rsn = 0;
    logic [3:0]  e_ent = 0;
    logic [31:0] e_rdata = 0;

    function automatic int hidx(input logic [47:0] a, input int t);
        case (t)
            0: return int'(a[47:36]);
            1: return int'(a[46:35]);
            2: return int'(a[45:34]);
            default: return int'(a[43:32]);
        endcase
    endfunction

    function automatic logic [31:0] mread(input int a);
        logic [31:0] r = '0;
        if (a < 32) begin
            if (a % 2 == 0) r = m_addr[a/2][31:0];
            else r = {m_vld[a/2], 15'd0, m_addr[a/2][47:32]};
        end else if (a >= 128 && a < 256) begin
            for (int b = 0; b < 32; b++) r[b] = m_hash[(a-128)*32 + b];
        end else if (a == 256) begin
            r = 32'(m_type);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin m_addr[i] = '0; m_vld[i] = 0; end
            for (int i = 0; i < 4096; i++) m_hash[i] = 0;
            m_type = 0;
            pend_idx.delete(); pend_cnt.delete();
            e_valid = 0; e_acc = 0; e_rsn = 0; e_ent = 0; e_rvalid = 0; e_rdata = 0;
        end else begin
            int  found;
            bit  busy;
            // lookup on contents before any write this edge (R10)
            e_valid = da_valid; e_acc = 0; e_rsn = 0; e_ent = 0;
            if (da_valid) begin
                found = -1;
                for (int i = 0; i < 16; i++)
                    if (found < 0 && m_vld[i] && m_addr[i] == da) found = i;
                if (found >= 0) begin
                    e_acc = 1; e_rsn = 2'd1; e_ent = 4'(found);
                end else if (da[0] && m_hash[hidx(da, m_type)]) begin
                    e_acc = 1; e_rsn = 2'd2;
                end
            end
            e_rvalid = cfg_rd;
            if (cfg_rd) e_rdata = mread(int'(cfg_addr));
            busy = pend_cnt.size() > 0;
            if (busy) begin
                pend_cnt[0] = pend_cnt[0] - 1;
                if (pend_cnt[0] == 0) begin
                    m_hash[pend_idx[0]] = 1;
                    void'(pend_idx.pop_front());
                    void'(pend_cnt.pop_front());
                end
            end
            if (cfg_wr) begin
                int a;
                a = int'(cfg_addr);
                if (a < 32) begin
                    if (a % 2 == 0) m_addr[a/2][31:0] = cfg_wdata;
                    else begin
                        m_addr[a/2][47:32] = cfg_wdata[15:0];
                        m_vld[a/2] = cfg_wdata[31];
                    end
                end else if (a >= 128 && a < 256) begin
                    for (int b = 0; b < 32; b++) m_hash[(a-128)*32 + b] = cfg_wdata[b];
                end else if (a == 256) begin
                    m_type = int'(cfg_wdata[1:0]);
                end else if (a == 257 && !busy) begin
                    pend_idx.push_back(int'(cfg_wdata[11:0]));
                    pend_cnt.push_back(2);
                end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        n_cmp++;
        if (hit_valid !== e_valid || hit_accept !== e_acc ||
            hit_reason !== e_rsn || hit_entry !== e_ent) begin
            n_bad++;
            $display("FAIL %s verdict: got v=%0b a=%0b r=%0d e=%0d expected v=%0b a=%0b r=%0d e=%0d",
                     cur_tag, hit_valid, hit_accept, hit_reason, hit_entry,
                     e_valid, e_acc, e_rsn, e_ent);
        end
        n_cmp++;
        if (cfg_rvalid !== e_rvalid || (e_rvalid && cfg_rdata !== e_rdata)) begin
            n_bad++;
            $display("FAIL %s readback: got v=%0b d=%08h expected v=%0b d=%08h",
                     cur_tag, cfg_rvalid, cfg_rdata, e_rvalid, e_rdata);
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic op(input bit w, input int a, input logic [31:0] d,
                      input bit r, input bit lv, input logic [47:0] ad);
        @(negedge clk);
        cfg_wr = w; cfg_addr = 9'(a); cfg_wdata = d; cfg_rd = r;
        da_valid = lv; da = ad;
    endtask
    task automatic nop();                 op(0, 0, 0, 0, 0, 0);  endtask
    task automatic wr(input int a, input logic [31:0] d); op(1, a, d, 0, 0, 0); endtask
    task automatic rd(input int a);       op(0, a, 0, 1, 0, 0);  endtask
    task automatic lk(input logic [47:0] ad); op(0, 0, 0, 0, 1, ad); endtask
    task automatic load_entry(input int e, input logic [47:0] ad);
        wr(2*e, ad[31:0]);
        wr(2*e + 1, {1'b1, 15'd0, ad[47:32]});
    endtask
    task automatic setbit(input int idx);
        wr(257, 32'(idx)); nop(); nop(); nop();
    endtask

    localparam logic [47:0] STA  = 48'h00_1B_21_3C_4D_5E;
    localparam logic [47:0] MC_A = 48'h7A_C3_90_00_5E_01;
    localparam logic [47:0] MC_B = 48'h33_33_00_00_00_FB;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty tables
        cur_tag = "R1";
        rd(0); rd(1); rd(31); rd(128); rd(255); rd(256);
        lk(STA); lk(MC_A); lk(48'hFFFF_FFFF_FFFF); nop();

        // R3: entry layout and readback
        cur_tag = "R3";
        load_entry(0, STA);
        rd(0); rd(1); wr(3, 32'h7FFF_ABCD); rd(3); nop();
        // R2: exact match, single-bit miss, lowest index
        cur_tag = "R2";
        lk(STA); lk(STA ^ 48'h1); lk(STA ^ 48'h8000_0000_0000);
        load_entry(5, MC_B); load_entry(3, MC_B);
        lk(MC_B); nop();
        // R4: clearing valid bit of entry 3 leaves entry 5 matching
        cur_tag = "R4";
        wr(7, 32'h0); lk(MC_B); rd(6); rd(7); nop();
        // R10: write and lookup in the same cycle
        cur_tag = "R10";
        op(1, 11, 32'h0, 0, 1, MC_B);
        lk(MC_B); nop();

        // R5/R6/R7/R8: each hash window
        for (int t = 0; t < 4; t++) begin
            logic [47:0] mc;
            logic [47:0] uc;
            int h;
            cur_tag = "R5";
            mc = MC_A ^ (48'(t) << 40);
            uc = mc & ~48'h1;
            h = hidx(mc, t);
            wr(256, 32'(t)); rd(256);
            lk(mc);
            cur_tag = "R7";
            setbit(h);
            lk(mc);
            cur_tag = "R8";
            lk(uc);
            cur_tag = "R6";
            rd(128 + h/32);
            setbit(h ^ 1);
            rd(128 + h/32);
            cur_tag = "R7";
            op(1, 257, 32'(h ^ 2), 0, 1, mc); lk(mc); lk(mc); lk(mc); rd(128 + h/32);
            cur_tag = "R6";
            wr(128 + h/32, 32'h0); lk(mc); rd(128 + h/32);
        end

        // R9: exact beats hash; latency across back-to-back strobes
        cur_tag = "R9";
        wr(256, 0); setbit(hidx(MC_A, 0));
        load_entry(1, MC_A);
        lk(MC_A); lk(MC_A); lk(STA); nop(); lk(MC_A ^ 48'h100); nop();

        // R11: unmapped words
        cur_tag = "R11";
        wr(300, 32'hFFFF_FFFF); rd(300); rd(64); rd(256); lk(STA); nop();

        // mixed traffic
        cur_tag = "R9";
        for (int k = 0; k < 400; k++) begin
            logic [47:0] a;
            int s;
            s = $urandom_range(0, 5);
            case (s)
                0: a = STA;
                1: a = MC_A;
                2: a = MC_B;
                3: a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
                4: a = MC_A ^ (48'($urandom_range(0, 15)) << 32);
                default: a = {16'($urandom), 32'($urandom)} | 48'h1;
            endcase
            if (k % 50 == 7) setbit(hidx(a, k % 4));
            if (k % 50 == 20) wr(256, 32'(k % 4));
            if (k % 13 == 0) op(0, 0, 0, 1, 1, a);
            else lk(a);
        end
        nop(); nop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule